// File: doc/BRIEF.md
# DRAM Bus Direction Arbiter

This block decides, cycle by cycle, whether a DRAM controller's shared data bus serves reads or writes. It watches how full the read queue and the write queue are. It holds one direction bit and tells the command scheduler whether a data burst may be issued now. It also tells the scheduler whether bank preparation (activate and precharge) may proceed.

Writes are drained as soon as no read is waiting. Writes are also forced in when the write queue reaches a high watermark. Once writes have been forced in while reads are waiting, draining continues down to a low watermark before the bus turns back to reads. This hysteresis keeps the bus from oscillating around one threshold. Each change of direction opens a turnaround gap, and the gap has a different length in each direction.

During the gap after a write-to-read change, bank preparation for reads is already allowed, so it overlaps the bus turnaround. During the gap after a read-to-write change, nothing is allowed. The block counts the bursts accepted in each direction between turnarounds and presents the total of the batch that just ended.

Top module: `tna_arbiter`

## Requirements
- R1: After reset the bus direction is read (`dir_wr`=0), `issue_ok`=1, `prep_ok`=1, `dir_flip`=0, and both batch outputs are 0.
- R2: In read mode with no gap pending, an empty read queue (`rd_count`=0) together with a nonzero `wr_count` turns the bus to write on the next clock edge.
- R3: In read mode with no gap pending, `wr_count` >= HI_WM turns the bus to write on the next edge even when reads are waiting. A `wr_count` of HI_WM-1 with reads waiting leaves the bus in read mode.
- R4: In write mode with reads waiting, the bus stays in write mode while `wr_count` > LO_WM. It returns to read mode on the edge after `wr_count` <= LO_WM.
- R5: In write mode with no reads waiting, the bus keeps writing while `wr_count` is nonzero. It returns to read mode on the edge after both counts are zero.
- R6: After a change to write mode, `issue_ok` and `prep_ok` are both 0 for exactly T_RTW cycles, then `issue_ok` returns to 1.
- R7: After a change to read mode, `issue_ok` is 0 for exactly T_WTR cycles while `prep_ok` stays 1 throughout.
- R8: While a turnaround gap is open (`issue_ok`=0), the direction does not change, whatever the queue counts.
- R9: A burst counts when `issue_fire` is 1 while `issue_ok` is 1, including in the cycle in which a direction change is decided. On leaving read mode, `rd_batch` takes the number of reads counted since the previous change, and `wr_batch` is unchanged. On leaving write mode, the same holds with the roles swapped. The running count saturates at 2^CW-1.
- R10: `issue_fire` pulses while `issue_ok` is 0 are ignored and do not enter any batch count.
- R11: `dir_flip` is 1 for exactly the first cycle spent in a new direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_count | input | CNT_W | Entries in the read queue |
| wr_count | input | CNT_W | Entries in the write queue |
| issue_fire | input | 1 | Scheduler issued a burst in the current direction this cycle |
| dir_wr | output | 1 | Bus direction: 0 read, 1 write |
| issue_ok | output | 1 | A data burst may be issued this cycle |
| prep_ok | output | 1 | Bank preparation may proceed this cycle |
| dir_flip | output | 1 | First cycle in a new direction |
| rd_batch | output | CW | Reads accepted in the last completed read batch |
| wr_batch | output | CW | Writes accepted in the last completed write batch |

## Verification
The embedded properties watch, on every cycle, the switching rules against the queue counts and the silence of `issue_ok` and `prep_ok` during each gap. They also check that a direction change is only requested once the gap has closed, and that latching one batch leaves the other batch total untouched. Only the bench scenarios can show exact batch totals, including saturation and the exclusion of fires made during a gap. They also show the full sequence of opportunistic drain, watermark entry, hysteresis exit and empty-queue exit, with the exact gap lengths in between.

// File: rtl/tna_pkg.sv
package tna_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } bus_dir_e;

  // Read mode: should the bus turn to writes?
  function automatic logic enter_write(input int rd, input int wr, input int hi);
    return ((rd == 0) && (wr > 0)) || (wr >= hi);
  endfunction

  // Write mode: should the bus turn back to reads?
  function automatic logic leave_write(input int rd, input int wr, input int lo);
    return ((rd > 0) && (wr <= lo)) || ((rd == 0) && (wr == 0));
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tna_dir_policy.sv
module tna_dir_policy
  import tna_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int HI_WM = 48,
  parameter int LO_WM = 16
) (
  input  bus_dir_e         dir,
  input  logic             gap_done,
  input  logic [CNT_W-1:0] rd_count,
  input  logic [CNT_W-1:0] wr_count,
  output logic             flip_req
);

  logic want_wr;
  logic want_rd;

  always_comb begin
    want_wr  = enter_write(int'(rd_count), int'(wr_count), HI_WM);
    want_rd  = leave_write(int'(rd_count), int'(wr_count), LO_WM);
    flip_req = gap_done && ((dir == DIR_RD) ? want_wr : want_rd);
  end

endmodule

// File: rtl/tna_gap_timer.sv
module tna_gap_timer
  import tna_pkg::*;
#(
  parameter int T_RTW = 4,
  parameter int T_WTR = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_wr,
  output logic done
);

  localparam int GW = $clog2(max2(T_RTW, T_WTR) + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_wr ? GW'(T_RTW) : GW'(T_WTR);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // Direction may only be reconsidered once the gap is closed
  p_load_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> done);

  p_gap_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done);

endmodule

// File: rtl/tna_batch_count.sv
module tna_batch_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          latch,
  input  logic          from_wr,
  output logic [CW-1:0] rd_batch,
  output logic [CW-1:0] wr_batch
);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_nx;

  always_comb begin
    run_nx = run_q;
    if (accept && (run_q != {CW{1'b1}})) run_nx = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= '0;
      rd_batch <= '0;
      wr_batch <= '0;
    end else if (latch) begin
      run_q <= '0;
      if (from_wr) wr_batch <= run_nx;
      else         rd_batch <= run_nx;
    end else begin
      run_q <= run_nx;
    end
  end

  p_rd_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && from_wr) |=> $stable(rd_batch));

  p_wr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !from_wr) |=> $stable(wr_batch));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> ($stable(rd_batch) && $stable(wr_batch)));

endmodule

// File: rtl/tna_arbiter.sv
module tna_arbiter
  import tna_pkg::*;
#(
  parameter int QDEPTH = 64,
  parameter int HI_WM  = 48,
  parameter int LO_WM  = 16,
  parameter int T_RTW  = 4,
  parameter int T_WTR  = 6,
  parameter int CW     = 8,
  parameter int CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rd_count,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             issue_fire,
  output logic             dir_wr,
  output logic             issue_ok,
  output logic             prep_ok,
  output logic             dir_flip,
  output logic [CW-1:0]    rd_batch,
  output logic [CW-1:0]    wr_batch
);

  localparam int SW = $clog2(max2(T_RTW, T_WTR) + 2);

  initial begin
    p_params_ok: assert (LO_WM < HI_WM && HI_WM <= QDEPTH && T_RTW >= 1 && T_WTR >= 1)
      else $error("watermark or gap parameters out of range");
  end

  bus_dir_e dir_q;
  logic     gap_done;
  logic     flip_req;
  logic     accept;
  logic     flip_q;

  tna_dir_policy #(.CNT_W(CNT_W), .HI_WM(HI_WM), .LO_WM(LO_WM)) u_policy (
    .dir      (dir_q),
    .gap_done (gap_done),
    .rd_count (rd_count),
    .wr_count (wr_count),
    .flip_req (flip_req)
  );

  tna_gap_timer #(.T_RTW(T_RTW), .T_WTR(T_WTR)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (flip_req),
    .load_wr (dir_q == DIR_RD),
    .done    (gap_done)
  );

  assign accept = issue_fire && gap_done;

  tna_batch_count #(.CW(CW)) u_batch (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .latch    (flip_req),
    .from_wr  (dir_q == DIR_WR),
    .rd_batch (rd_batch),
    .wr_batch (wr_batch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= DIR_RD;
      flip_q <= 1'b0;
    end else begin
      flip_q <= flip_req;
      if (flip_req) dir_q <= (dir_q == DIR_RD) ? DIR_WR : DIR_RD;
    end
  end

  assign dir_wr   = (dir_q == DIR_WR);
  assign issue_ok = gap_done;
  assign prep_ok  = gap_done || (dir_q == DIR_RD);
  assign dir_flip = flip_q;

  // Independent cycle count since the last direction change, for gap checks
  logic [SW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                       since_q <= {SW{1'b1}};
    else if (flip_req)                since_q <= SW'(1);
    else if (since_q != {SW{1'b1}})   since_q <= since_q + 1'b1;
  end

  p_to_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_wr && issue_ok && rd_count == '0 && wr_count != '0) |=> dir_wr);

  p_hi_wm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_wr && issue_ok && int'(wr_count) >= HI_WM) |=> dir_wr);

  p_hyst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_wr && rd_count != '0 && int'(wr_count) > LO_WM) |=> dir_wr);

  p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_wr && rd_count == '0 && wr_count != '0) |=> dir_wr);

  p_rtw_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_wr && int'(since_q) <= T_RTW) |-> (!issue_ok && !prep_ok));

  p_wtr_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_wr && int'(since_q) <= T_WTR) |-> (!issue_ok && prep_ok));

  p_gap_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since_q) > max2(T_RTW, T_WTR)) |-> issue_ok);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_ok |=> $stable(dir_wr));

  p_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dir_flip |-> (since_q == SW'(1)));

endmodule

// File: tb/sim_tna_arbiter.sv
module sim_tna_arbiter;

  localparam int QDEPTH = 64;
  localparam int HI     = 48;
  localparam int LO     = 16;
  localparam int TRW    = 4;
  localparam int TWR    = 6;
  localparam int CW     = 8;
  localparam int CNT_W  = $clog2(QDEPTH + 1);
  localparam int SATV   = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] rd_count = '0;
  logic [CNT_W-1:0] wr_count = '0;
  logic issue_fire = 1'b0;
  logic dir_wr, issue_ok, prep_ok, dir_flip;
  logic [CW-1:0] rd_batch, wr_batch;

  always #2 clk = ~clk;

  tna_arbiter #(.QDEPTH(QDEPTH), .HI_WM(HI), .LO_WM(LO), .T_RTW(TRW),
                .T_WTR(TWR), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_count(rd_count), .wr_count(wr_count),
    .issue_fire(issue_fire), .dir_wr(dir_wr), .issue_ok(issue_ok),
    .prep_ok(prep_ok), .dir_flip(dir_flip), .rd_batch(rd_batch),
    .wr_batch(wr_batch)
  );

  typedef struct {
    logic  wr, ok, prep, flip;
    int    rdb, wrb;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  // reference state
  bit m_wr = 0;
  int m_age = 1000;  // cycles since last change
  int m_run = 0;
  int m_rdb = 0;
  int m_wrb = 0;

  function automatic bit open_now(bit w, int age);
    return age > (w ? TRW : TWR);
  endfunction

  task automatic step(input int rd, input int wr, input bit fire, input string tag);
    exp_t e;
    bit   ok, sw, take;
    @(negedge clk);
    rd_count   = CNT_W'(rd);
    wr_count   = CNT_W'(wr);
    issue_fire = fire;
    ok   = open_now(m_wr, m_age);
    take = fire && ok;
    if (!m_wr) sw = ok && ((rd == 0 && wr != 0) || wr >= HI);
    else       sw = ok && ((rd != 0 && wr <= LO) || (rd == 0 && wr == 0));
    if (take && m_run < SATV) m_run++;
    if (sw) begin
      if (m_wr) m_wrb = m_run; else m_rdb = m_run;
      m_run = 0;
      m_wr  = !m_wr;
      m_age = 1;
    end else if (m_age < 1000) begin
      m_age++;
    end
    e.wr   = m_wr;
    e.ok   = open_now(m_wr, m_age);
    e.prep = !m_wr || e.ok;
    e.flip = sw;
    e.rdb  = m_rdb;
    e.wrb  = m_wrb;
    e.tag  = tag;
    q.push_back(e);
  endtask

  // monitor: compare after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (dir_wr !== e.wr || issue_ok !== e.ok || prep_ok !== e.prep ||
            dir_flip !== e.flip || int'(rd_batch) != e.rdb || int'(wr_batch) != e.wrb) begin
          n_bad++;
          $display("FAIL %s: got dir=%0b ok=%0b prep=%0b flip=%0b rdb=%0d wrb=%0d exp dir=%0b ok=%0b prep=%0b flip=%0b rdb=%0d wrb=%0d",
                   e.tag, dir_wr, issue_ok, prep_ok, dir_flip, rd_batch, wr_batch,
                   e.wr, e.ok, e.prep, e.flip, e.rdb, e.wrb);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    n_chk++;
    if (dir_wr !== 1'b0 || issue_ok !== 1'b1 || prep_ok !== 1'b1 || dir_flip !== 1'b0 ||
        rd_batch != '0 || wr_batch != '0) begin
      n_bad++;
      $display("FAIL R1: got dir=%0b ok=%0b prep=%0b flip=%0b rdb=%0d wrb=%0d exp 0 1 1 0 0 0",
               dir_wr, issue_ok, prep_ok, dir_flip, rd_batch, wr_batch);
    end

    // reads with fires (R9)
    repeat (3) step(5, 0, 1, "R9");
    step(5, 0, 0, "R9");
    // opportunistic entry into writes (R2, R11)
    step(0, 3, 0, "R2");
    // fires during read-to-write gap are ignored (R6, R10)
    repeat (TRW) step(0, 3, 1, "R10");
    // drain with no reads until empty (R5)
    step(0, 3, 1, "R5");
    step(0, 2, 1, "R5");
    step(0, 1, 1, "R5");
    step(0, 0, 0, "R5");
    // write-to-read gap with preparation allowed; entry conditions held off (R7, R8)
    repeat (TWR) step(0, 5, 0, "R8");
    step(0, 5, 0, "R2");
    // leave condition during write gap is held off (R8)
    repeat (TRW) step(2, 5, 0, "R8");
    step(2, 5, 0, "R4");
    repeat (TWR) step(2, 20, 1, "R7");
    // high watermark with reads waiting (R3)
    step(2, HI - 1, 1, "R3");
    step(2, HI - 1, 1, "R3");
    step(2, HI, 1, "R3");
    repeat (TRW) step(2, HI, 0, "R6");
    // hysteresis down to the low watermark (R4)
    step(2, 30, 1, "R4");
    step(2, LO + 1, 1, "R4");
    step(2, LO, 1, "R4");
    repeat (TWR) step(3, 0, 0, "R7");
    // saturation of the batch count (R9)
    repeat (300) step(3, 0, 1, "R9");
    step(0, 1, 0, "R9");
    repeat (TRW + 2) step(0, 1, 0, "R6");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule